// File: doc/BRIEF.md
# Serial-Loaded Multichannel Converter Register Bank

This block holds the digital state of a bank of voltage-output converter channels and fills it from a three-wire serial link. A command word is framed by an active-low frame enable. It arrives one bit per falling edge of a serial clock, most significant bit first. Once all 16 bits are in, the word is decoded into one of three writes: a global coding setting, the bias-source select of one channel, or a new code for one channel's 10-bit main converter or 8-bit trim converter. The serial clock, frame enable and data are sampled on the system clock `clk`, which must run well above the serial bit rate.

Every converter path is double buffered. A write lands in a staging register, and the value driven on the block's outputs changes only when the active-low load input is low at a clock edge. Holding load low through the last bit of a frame makes the addressed output follow that word at once. Tying load low makes every write show through directly. An active-low clear input acts asynchronously on the outputs only. It drives every main output to the centre code of the current coding and every trim output to zero. The staging registers keep their values, so a later load brings them back.

The serial link has no back-pressure and no ready signal. A word that completes is always accepted at its 16th bit. The analog parts are not in this block. It exposes the register contents as plain outputs.

Top module: `sdac_regbank`

## Requirements
- R1: While `ser_fs_n` is low, one bit of `ser_din` is captured at each falling edge of `ser_clk`. The first bit captured is word bit 15 and the 16th is bit 0. The word acts at the `clk` edge that samples its 16th falling edge.
- R2: A word whose bits 14:13 are 00 writes the coding bit from bit 0 (1 = twos complement, 0 = offset binary), shown on `twos_coding`. Bits 12:10 are ignored for this write.
- R3: A word whose bits 14:13 are 01 writes bits 1:0 into the bias select of the channel named by bits 12:10. The codes are 00 half supply, 01 internal reference and 10 external reference. The value is shown at once on that channel's `bias_sel` field.
- R4: A word whose bit 14 is 1 is a data write to channel bits 12:10. If bit 15 is 0, bits 9:0 go to the main staging register. If bit 15 is 1, bits 7:0 go to the trim staging register. While `load_n` stays high, no output changes.
- R5: At every `clk` edge where `load_n` is low and `clr_n` is high, every main and trim output takes the value its staging register holds after that edge.
- R6: If `load_n` is low at the edge that completes a data word, or is held low, the addressed output shows the new code after that same edge.
- R7: While `clr_n` is low, without waiting for `clk`, every main output reads 10'h200 when the coding is offset binary and 10'h000 when it is twos complement. Every trim output reads 0. Staging registers, bias selects and coding are unchanged.
- R8: If `ser_fs_n` rises before 16 bits have arrived, the partial word is dropped, no register is written, and the next frame starts again at bit 15.
- R9: Bits that arrive after the 16th within the same frame are ignored.
- R10: A channel control or data write to a channel number at or above `NUM_CH` changes nothing.
- R11: After `rst_n`, every main staging register and output holds 10'h200, every trim register holds 0, every bias select is 00 and the coding is offset binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and register updates |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low output clear |
| load_n | input | 1 | Active-low level load: staging registers to outputs |
| ser_clk | input | 1 | Serial bit clock; bits taken on its falling edge |
| ser_fs_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Serial data, MSB first |
| twos_coding | output | 1 | Coding bit: 1 twos complement, 0 offset binary |
| bias_sel | output | 2*NUM_CH | Bias select per channel, channel 0 in the low bits |
| main_out | output | 10*NUM_CH | Main converter output codes, channel 0 in the low bits |
| sub_out | output | 8*NUM_CH | Trim converter output codes, channel 0 in the low bits |

## Verification
The embedded properties assume the serial inputs are synchronous to `clk`. They assume each serial clock level lasts at least one `clk` cycle, and that `clr_n` never pulses low and back high between two clock edges. The stimulus holds every serial clock phase for two cycles. It moves frame enable only while the serial clock is high. It changes `clr_n` and `load_n` just after a rising edge and holds them for at least one full cycle. Under these conditions the bench can track the block edge by edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int FRAME_BITS = 16;
  localparam int PATH_BIT   = 15;
  localparam int MODE_HI    = 14;
  localparam int MODE_LO    = 13;
  localparam int ADDR_HI    = 12;
  localparam int ADDR_LO    = 10;
  localparam int ADDR_W     = ADDR_HI - ADDR_LO + 1;
  localparam int BIAS_W     = 2;

  typedef enum logic [1:0] {
    TGT_SYS   = 2'b00,
    TGT_CHCTL = 2'b01,
    TGT_DATA  = 2'b10
  } tgt_e;

  function automatic tgt_e decode_tgt(input logic [1:0] md);
    tgt_e t;
    if (md[1])      t = TGT_DATA;
    else if (md[0]) t = TGT_CHCTL;
    else            t = TGT_SYS;
    return t;
  endfunction

endpackage

// File: rtl/sdac_ser_rx.sv
module sdac_ser_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               fs_n,
  input  logic               sdi,
  output logic               word_vld,
  output logic [FRAME_W-1:0] word
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               sclk_q;
  logic [FRAME_W-2:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               take;

  // a bit is taken on a high-to-low step of the serial clock inside a frame
  assign take     = sclk_q && !sclk && !fs_n && (cnt < CNT_FULL);
  assign word     = {shreg, sdi};
  assign word_vld = take && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      if (fs_n) begin
        cnt <= '0;
      end else if (take) begin
        shreg <= {shreg[FRAME_W-3:0], sdi};
        cnt   <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL); // R9

  AST_WORD_ENDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> (cnt == CNT_FULL)); // R9

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fs_n |=> (cnt == '0)); // R8

endmodule

// File: rtl/sdac_cmd_dec.sv
module sdac_cmd_dec
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8
) (
  input  logic                  word_vld,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  sys_we,
  output logic                  sys_twos,
  output logic [NUM_CH-1:0]     ctl_we,
  output logic [BIAS_W-1:0]     ctl_bias,
  output logic [NUM_CH-1:0]     main_we,
  output logic [NUM_CH-1:0]     sub_we,
  output logic [MAIN_W-1:0]     main_val,
  output logic [SUB_W-1:0]      sub_val
);
  tgt_e              tgt;
  logic [ADDR_W-1:0] ch;
  logic              to_sub;

  assign tgt      = decode_tgt(word[MODE_HI:MODE_LO]);
  assign ch       = word[ADDR_HI:ADDR_LO];
  assign to_sub   = word[PATH_BIT];
  assign sys_we   = word_vld && (tgt == TGT_SYS);
  assign sys_twos = word[0];
  assign ctl_bias = word[BIAS_W-1:0];
  assign main_val = word[MAIN_W-1:0];
  assign sub_val  = word[SUB_W-1:0];

  // one strobe set per channel; addresses at or above NUM_CH hit nothing
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    logic hit;
    assign hit        = word_vld && (ch == ADDR_W'(g));
    assign ctl_we[g]  = hit && (tgt == TGT_CHCTL);
    assign main_we[g] = hit && (tgt == TGT_DATA) && !to_sub;
    assign sub_we[g]  = hit && (tgt == TGT_DATA) && to_sub;
  end

endmodule

// File: rtl/sdac_chan.sv
module sdac_chan
  import sdac_pkg::*;
#(
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              twos,
  input  logic              ctl_we,
  input  logic [BIAS_W-1:0] bias_in,
  input  logic              main_we,
  input  logic              sub_we,
  input  logic [MAIN_W-1:0] main_val,
  input  logic [SUB_W-1:0]  sub_val,
  output logic [MAIN_W-1:0] main_out,
  output logic [SUB_W-1:0]  sub_out,
  output logic [BIAS_W-1:0] bias_sel
);
  localparam logic [MAIN_W-1:0] MAIN_MID = {1'b1, {(MAIN_W-1){1'b0}}};

  logic [MAIN_W-1:0] main_dat, main_nxt, main_clr;
  logic [SUB_W-1:0]  sub_dat, sub_nxt;

  assign main_nxt = main_we ? main_val : main_dat;
  assign sub_nxt  = sub_we  ? sub_val  : sub_dat;
  assign main_clr = twos ? '0 : MAIN_MID;

  // staging side: written by decoded commands only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_dat <= MAIN_MID;
      sub_dat  <= '0;
      bias_sel <= '0;
    end else begin
      main_dat <= main_nxt;
      sub_dat  <= sub_nxt;
      if (ctl_we) bias_sel <= bias_in;
    end
  end

  // output side: level load, asynchronous clear
  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n) begin
      main_out <= MAIN_MID;
      sub_out  <= '0;
    end else if (!clr_n) begin
      main_out <= main_clr;
      sub_out  <= '0;
    end else if (!load_n) begin
      main_out <= main_nxt;
      sub_out  <= sub_nxt;
    end
  end

  AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (main_out == (twos ? '0 : MAIN_MID)) && (sub_out == '0)); // R7

  AST_LOAD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !load_n |=> (main_out == main_dat) && (sub_out == sub_dat)); // R5

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    load_n |=> $stable(main_out) && $stable(sub_out)); // R4

endmodule

// File: rtl/sdac_regbank.sv
module sdac_regbank
  import sdac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int MAIN_W = 10,
  parameter int SUB_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       ser_clk,
  input  logic                       ser_fs_n,
  input  logic                       ser_din,
  output logic                       twos_coding,
  output logic [NUM_CH*BIAS_W-1:0]   bias_sel,
  output logic [NUM_CH*MAIN_W-1:0]   main_out,
  output logic [NUM_CH*SUB_W-1:0]    sub_out
);
  logic                  word_vld;
  logic [FRAME_BITS-1:0] word;
  logic                  sys_we, sys_twos;
  logic [NUM_CH-1:0]     ctl_we, main_we, sub_we;
  logic [BIAS_W-1:0]     ctl_bias;
  logic [MAIN_W-1:0]     main_val;
  logic [SUB_W-1:0]      sub_val;

  sdac_ser_rx #(.FRAME_W(FRAME_BITS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (ser_clk),
    .fs_n     (ser_fs_n),
    .sdi      (ser_din),
    .word_vld (word_vld),
    .word     (word)
  );

  sdac_cmd_dec #(.NUM_CH(NUM_CH), .MAIN_W(MAIN_W), .SUB_W(SUB_W)) u_dec (
    .word_vld (word_vld),
    .word     (word),
    .sys_we   (sys_we),
    .sys_twos (sys_twos),
    .ctl_we   (ctl_we),
    .ctl_bias (ctl_bias),
    .main_we  (main_we),
    .sub_we   (sub_we),
    .main_val (main_val),
    .sub_val  (sub_val)
  );

  // global control: coding selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      twos_coding <= 1'b0;
    else if (sys_we) twos_coding <= sys_twos;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    sdac_chan #(.MAIN_W(MAIN_W), .SUB_W(SUB_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .twos     (twos_coding),
      .ctl_we   (ctl_we[g]),
      .bias_in  (ctl_bias),
      .main_we  (main_we[g]),
      .sub_we   (sub_we[g]),
      .main_val (main_val),
      .sub_val  (sub_val),
      .main_out (main_out[g*MAIN_W +: MAIN_W]),
      .sub_out  (sub_out[g*SUB_W +: SUB_W]),
      .bias_sel (bias_sel[g*BIAS_W +: BIAS_W])
    );
  end

  AST_CODING_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> $stable(twos_coding)); // R2

endmodule

// File: tb/sdac_regbank_tb.sv
module sdac_regbank_tb;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, load_n = 1'b1;
  logic ser_clk = 1'b1, ser_fs_n = 1'b1, ser_din = 1'b0;
  logic               twos_coding;
  logic [NCH*2-1:0]   bias_sel;
  logic [NCH*10-1:0]  main_out;
  logic [NCH*8-1:0]   sub_out;

  int n_tests = 0, n_fail = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdac_regbank #(.NUM_CH(NCH), .MAIN_W(10), .SUB_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .ser_clk(ser_clk), .ser_fs_n(ser_fs_n), .ser_din(ser_din),
    .twos_coding(twos_coding), .bias_sel(bias_sel),
    .main_out(main_out), .sub_out(sub_out)
  );

  // behavioural reference
  int m_main_d[NCH], m_sub_d[NCH], m_main_o[NCH], m_sub_o[NCH], m_bias[NCH];
  int m_twos, m_cnt;
  int m_sh;
  logic m_prev;

  task automatic m_apply(input int w);
    int md, ch;
    md = (w >> 13) & 3;
    ch = (w >> 10) & 7;
    if (md == 0) m_twos = w & 1;
    else if (md == 1) begin
      if (ch < NCH) m_bias[ch] = w & 3;
    end else if (ch < NCH) begin
      if (((w >> 15) & 1) == 0) m_main_d[ch] = w & 'h3FF;
      else m_sub_d[ch] = w & 'hFF;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_main_d[c] = 'h200; m_main_o[c] = 'h200;
        m_sub_d[c] = 0; m_sub_o[c] = 0; m_bias[c] = 0;
      end
      m_twos = 0; m_cnt = 0; m_sh = 0; m_prev = 1'b1;
    end else begin
      int old_twos;
      old_twos = m_twos;
      if (ser_fs_n) m_cnt = 0;
      else if (m_prev && !ser_clk && m_cnt < 16) begin
        m_sh = ((m_sh << 1) | int'(ser_din)) & 'hFFFF;
        m_cnt++;
        if (m_cnt == 16) m_apply(m_sh);
      end
      m_prev = ser_clk;
      for (int c = 0; c < NCH; c++) begin
        if (!clr_n) begin
          m_main_o[c] = old_twos ? 0 : 'h200; m_sub_o[c] = 0;
        end else if (!load_n) begin
          m_main_o[c] = m_main_d[c]; m_sub_o[c] = m_sub_d[c];
        end
      end
    end
  end

  function automatic int mo(int c); return int'(main_out[c*10 +: 10]); endfunction
  function automatic int so(int c); return int'(sub_out[c*8 +: 8]); endfunction
  function automatic int bo(int c); return int'(bias_sel[c*2 +: 2]); endfunction

  // edge-by-edge comparison against the reference (all requirements)
  always @(negedge clk) begin
    if (live && !done) begin
      bit bad;
      bad = (int'(twos_coding) != m_twos);
      for (int c = 0; c < NCH; c++) begin
        int em, es;
        em = !clr_n ? (m_twos ? 0 : 'h200) : m_main_o[c];
        es = !clr_n ? 0 : m_sub_o[c];
        if (mo(c) != em || so(c) != es || bo(c) != m_bias[c]) bad = 1'b1;
        if (mo(c) != em)
          $display("FAIL MODEL ch%0d main actual=%h expected=%h", c, mo(c), em);
        if (so(c) != es)
          $display("FAIL MODEL ch%0d sub actual=%h expected=%h", c, so(c), es);
        if (bo(c) != m_bias[c])
          $display("FAIL MODEL ch%0d bias actual=%0d expected=%0d", c, bo(c), m_bias[c]);
      end
      if (int'(twos_coding) != m_twos)
        $display("FAIL MODEL coding actual=%0d expected=%0d", twos_coding, m_twos);
      n_tests++;
      if (bad) n_fail++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_load();
    load_n = 1'b0; cyc(1); load_n = 1'b1; cyc(1);
  endtask

  // sends the low n bits of bits, most significant first
  task automatic send_bits(input logic [31:0] bits, input int n, input bit ld_last);
    ser_fs_n = 1'b0; cyc(2);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = bits[i];
      ser_clk = 1'b1; cyc(2);
      if (ld_last && i == n - 16) load_n = 1'b0;
      ser_clk = 1'b0; cyc(2);
      if (ld_last && i == n - 16) load_n = 1'b1;
    end
    ser_clk = 1'b1; cyc(2);
    ser_fs_n = 1'b1; cyc(2);
  endtask

  function automatic logic [15:0] w_main(int ch, int v);
    return {1'b0, 2'b10, 3'(ch), 10'(v)};
  endfunction
  function automatic logic [15:0] w_sub(int ch, int v);
    return {1'b1, 2'b10, 3'(ch), 2'b00, 8'(v)};
  endfunction
  function automatic logic [15:0] w_ctl(int ch, int b);
    return {1'b0, 2'b01, 3'(ch), 8'h00, 2'(b)};
  endfunction
  function automatic logic [15:0] w_sys(int tw);
    return {1'b0, 2'b00, 3'b101, 9'h000, 1'(tw)};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    live = 1'b1;

    // R11 reset state
    chk("R11 main ch0", mo(0), 'h200);
    chk("R11 sub ch3", so(3), 0);
    chk("R11 bias ch2", bo(2), 0);
    chk("R11 coding", int'(twos_coding), 0);

    // R4 staged main write, R1 bit order
    send_bits(32'(w_main(1, 'h155)), 16, 1'b0);
    chk("R4 main ch1 held", mo(1), 'h200);
    pulse_load();
    chk("R5 R1 main ch1 loaded", mo(1), 'h155);

    // R4 staged sub write
    send_bits(32'(w_sub(2, 'hA5)), 16, 1'b0);
    chk("R4 sub ch2 held", so(2), 0);
    chk("R4 main ch2 untouched", mo(2), 'h200);

    // R6 load low at the 16th edge
    send_bits(32'(w_main(3, 'h3C3)), 16, 1'b1);
    chk("R6 main ch3 auto", mo(3), 'h3C3);
    chk("R5 sub ch2 follows", so(2), 'hA5);

    // R3 channel control
    send_bits(32'(w_ctl(0, 2)), 16, 1'b0);
    chk("R3 bias ch0", bo(0), 2);
    chk("R3 bias ch1 untouched", bo(1), 0);

    // R2 coding, address bits ignored
    send_bits(32'(w_sys(1)), 16, 1'b0);
    chk("R2 coding twos", int'(twos_coding), 1);

    // R7 clear under twos complement
    clr_n = 1'b0; cyc(1);
    chk("R7 main ch1 twos clear", mo(1), 0);
    chk("R7 main ch3 twos clear", mo(3), 0);
    chk("R7 sub ch2 clear", so(2), 0);
    chk("R7 bias kept", bo(0), 2);
    clr_n = 1'b1; cyc(1);
    pulse_load();
    chk("R7 staging kept ch1", mo(1), 'h155);
    chk("R7 staging kept sub ch2", so(2), 'hA5);

    // R7 clear under offset binary
    send_bits(32'(w_sys(0)), 16, 1'b0);
    chk("R2 coding offset", int'(twos_coding), 0);
    clr_n = 1'b0; cyc(1);
    chk("R7 main ch3 offset clear", mo(3), 'h200);
    clr_n = 1'b1; cyc(1);
    pulse_load();

    // R8 aborted frame
    send_bits(32'(w_main(0, 'h3FF)) >> 6, 10, 1'b0);
    pulse_load();
    chk("R8 partial dropped ch0", mo(0), 'h200);
    send_bits(32'(w_main(0, 'h0AA)), 16, 1'b0);
    pulse_load();
    chk("R8 next frame aligned", mo(0), 'h0AA);

    // R9 trailing bits ignored
    send_bits({w_main(1, 'h111), w_main(2, 'h0F0)}, 32, 1'b0);
    pulse_load();
    chk("R9 first word taken", mo(1), 'h111);
    chk("R9 trailing word ignored", mo(2), 'h200);

    // R10 out-of-range channel
    send_bits(32'(w_main(5, 'h2AA)), 16, 1'b0);
    send_bits(32'(w_ctl(6, 3)), 16, 1'b0);
    pulse_load();
    chk("R10 ch0", mo(0), 'h0AA);
    chk("R10 ch1", mo(1), 'h111);
    chk("R10 ch2", mo(2), 'h200);
    chk("R10 ch3", mo(3), 'h3C3);
    chk("R10 bias ch2", bo(2), 0);

    // R6 load tied low
    load_n = 1'b0;
    send_bits(32'(w_sub(0, 'h5A)), 16, 1'b0);
    chk("R6 tied low sub ch0", so(0), 'h5A);
    load_n = 1'b1; cyc(2);

    finish_run();
  end

endmodule